// File: doc/BRIEF.md
# Programmable Interval Counter

A single 16-bit down-counter with a gate input and one waveform output, programmed from an 8-bit processor port. The processor first writes a setup byte that picks the counting mode and the byte format. It then writes the start count. On the next count pulse the count moves into the counting element. From there the output follows one of three waveforms: a one-time terminal-count flag, a periodic one-pulse-wide low strobe, or a square wave. Reads always go through an output latch. A freeze command can snapshot the running count, so that both bytes of one instant can be read back.

All logic runs on `clk_i`. The counting clock is the one-cycle strobe `tick_i`, and `gate_i` is sampled only on cycles where `tick_i` is high. The setup byte takes effect at the next `clk_i` edge and needs no count pulse.

Control byte (written with `sel_ctrl_i` high):
- bits [3:2] select the byte format: 00 freeze the count, 01 low byte only, 10 high byte only, 11 low byte then high byte;
- bits [1:0] select the mode: 00 terminal-count flag, 01 rate strobe, 10 square wave, 11 rate strobe;
- bits [7:4] are ignored.

Top module: `pic_timer`

## Requirements
- R1: After reset `out_o` is 1 and `rdata_o` is 0x00.
- R2: A setup byte stops counting at the next `clk_i` edge with no count pulse needed. It sets `out_o` to 0 for mode 00 and to 1 for every other mode.
- R3: A written count enters the counting element on the first `tick_i` after the write, and no earlier. Without `tick_i`, `out_o` never changes except through a processor write.
- R4: In mode 00, `out_o` stays 0 until the N-th pulse after the loading pulse and goes to 1 on that pulse. It then stays 1 until the next write.
- R5: In mode 00 with format 11, the first byte of a count drives `out_o` to 0 and halts counting at once. Counting resumes from the new value after the second byte and the next pulse.
- R6: In mode 01 the output period is N pulses, and `out_o` is 0 for exactly one pulse of each period.
- R7: In mode 10, `out_o` is 1 for ceil(N/2) pulses and 0 for floor(N/2) pulses. The count steps by two, with one odd step when N is odd.
- R8: A low `gate_i` holds the count. In modes 01 and 10 it also forces `out_o` to 1.
- R9: In modes 01 and 10, a rising `gate_i` seen on a pulse reloads the start count, and the period restarts from there.
- R10: The freeze command (format 00) holds the snapshot on `rdata_o` until every byte of the format has been read. It changes neither the mode nor `out_o`.
- R11: Reads return the low byte for format 01 and the high byte for format 10. For format 11 they return the low byte, then the high byte, with a toggle that advances on each `rd_i`.
- R12: A count of 0 counts as 65536: the first pulse after the load moves the counter to 0xFFFF without reaching terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count pulse, one cycle wide |
| gate_i | input | 1 | Count gate, sampled on count pulses |
| wr_i | input | 1 | Processor write strobe |
| rd_i | input | 1 | Processor read strobe (advances the byte toggle) |
| sel_ctrl_i | input | 1 | 1 selects the control byte, 0 selects the count data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data taken from the output latch |
| out_o | output | 1 | Counter waveform output |

## Verification
The bench targets the odd-count square wave. A design that always subtracts two would give equal halves, or would underflow past zero and stretch one half to thousands of pulses. It also checks the split two-byte write in terminal-count mode. A design that keeps counting after the first byte would return 0xFFFE instead of a held zero, and would leave the output high. A count of zero must read back as 0xFFFF after one pulse, without raising the flag. A frozen snapshot must survive pulses between its two byte reads. A design that lets the latch follow the counter would return a torn pair. A rising gate must restart the period, which a design that only enables counting on the gate would not do.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  typedef enum logic [1:0] {
    MODE_TC     = 2'd0,
    MODE_RATE   = 2'd1,
    MODE_SQUARE = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    FMT_LATCH = 2'd0,
    FMT_LO    = 2'd1,
    FMT_HI    = 2'd2,
    FMT_LOHI  = 2'd3
  } fmt_e;

  function automatic mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'd0:    return MODE_TC;
      2'd2:    return MODE_SQUARE;
      default: return MODE_RATE;
    endcase
  endfunction
endpackage

// File: rtl/pic_host_if.sv
`timescale 1ns/1ps
module pic_host_if
  import pic_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned CW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          sel_ctrl_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [CW-1:0] count_i,
  output logic [DW-1:0] rdata_o,
  output mode_e         mode_o,
  output mode_e         cfg_mode_o,
  output logic          cfg_stb_o,
  output logic          first_stb_o,
  output logic          load_stb_o,
  output logic [CW-1:0] reload_o,
  output logic          latched_o
);
  logic ctrl_wr, data_wr, data_rd, is_latch;
  logic unused_hi;
  mode_e         mode_q;
  fmt_e          fmt_q;
  logic          wr_hi_q, rd_hi_q, latched_q;
  logic [CW-1:0] reload_q, ol_q;

  assign ctrl_wr   = wr_i & sel_ctrl_i;
  assign data_wr   = wr_i & ~sel_ctrl_i;
  assign data_rd   = rd_i & ~sel_ctrl_i;
  assign is_latch  = ctrl_wr & (wdata_i[3:2] == FMT_LATCH);
  assign cfg_stb_o = ctrl_wr & ~is_latch;
  assign unused_hi = ^wdata_i[DW-1:4];

  assign cfg_mode_o  = decode_mode(wdata_i[1:0]);
  assign first_stb_o = data_wr & (fmt_q == FMT_LOHI) & ~wr_hi_q;
  assign load_stb_o  = data_wr & ((fmt_q != FMT_LOHI) | wr_hi_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_TC;
      fmt_q     <= FMT_LOHI;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      latched_q <= 1'b0;
      reload_q  <= '0;
      ol_q      <= '0;
    end else if (cfg_stb_o) begin
      mode_q    <= cfg_mode_o;
      fmt_q     <= fmt_e'(wdata_i[3:2]);
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      latched_q <= 1'b0;
    end else begin
      // output latch follows the counter until frozen
      if (!latched_q) ol_q <= count_i;
      if (is_latch) latched_q <= 1'b1;
      if (data_wr) begin
        case (fmt_q)
          FMT_LO: reload_q <= {{DW{1'b0}}, wdata_i};
          FMT_HI: reload_q <= {wdata_i, {DW{1'b0}}};
          default: begin
            if (!wr_hi_q) reload_q[DW-1:0]  <= wdata_i;
            else          reload_q[CW-1:DW] <= wdata_i;
            wr_hi_q <= ~wr_hi_q;
          end
        endcase
      end
      if (data_rd) begin
        if (fmt_q == FMT_LOHI) rd_hi_q <= ~rd_hi_q;
        if ((fmt_q != FMT_LOHI) || rd_hi_q) latched_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (fmt_q)
      FMT_HI:   rdata_o = ol_q[CW-1:DW];
      FMT_LOHI: rdata_o = rd_hi_q ? ol_q[CW-1:DW] : ol_q[DW-1:0];
      default:  rdata_o = ol_q[DW-1:0];
    endcase
  end

  assign mode_o    = mode_q;
  assign reload_o  = reload_q;
  assign latched_o = latched_q;
endmodule

// File: rtl/pic_count_core.sv
`timescale 1ns/1ps
module pic_count_core
  import pic_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          gate_i,
  input  mode_e         mode_i,
  input  logic          cfg_stb_i,
  input  mode_e         cfg_mode_i,
  input  logic          first_stb_i,
  input  logic          load_stb_i,
  input  logic [CW-1:0] reload_i,
  output logic [CW-1:0] count_o,
  output logic          out_o
);
  logic [CW-1:0] ce_q, step;
  logic          out_q, run_q, pend_q, gate_q;
  logic          gate_rise, sq_expire;

  // square wave: even counts step by 2; odd counts take one extra step of 1 (high) or 3 (low)
  always_comb begin
    if (!ce_q[0])   step = CW'(2);
    else if (out_q) step = CW'(1);
    else            step = CW'(3);
  end

  assign sq_expire = (ce_q != '0) && (ce_q <= step);
  assign gate_rise = gate_i & ~gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q   <= '0;
      out_q  <= 1'b1;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      gate_q <= 1'b0;
    end else if (cfg_stb_i) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      out_q  <= (cfg_mode_i != MODE_TC);
    end else begin
      if (tick_i) begin
        gate_q <= gate_i;
        if (pend_q && (!run_q || mode_i == MODE_TC)) begin
          ce_q   <= reload_i;
          run_q  <= 1'b1;
          pend_q <= 1'b0;
        end else if (run_q) begin
          case (mode_i)
            MODE_TC: begin
              if (gate_i) begin
                ce_q <= ce_q - CW'(1);
                if (ce_q == CW'(1)) out_q <= 1'b1;
              end
            end
            MODE_RATE: begin
              if (!gate_i) begin
                out_q <= 1'b1;
              end else if (gate_rise || ce_q == CW'(1)) begin
                ce_q  <= reload_i;
                out_q <= 1'b1;
              end else begin
                ce_q <= ce_q - CW'(1);
                if (ce_q == CW'(2)) out_q <= 1'b0;
              end
            end
            default: begin
              if (!gate_i) begin
                out_q <= 1'b1;
              end else if (gate_rise) begin
                ce_q  <= reload_i;
                out_q <= 1'b1;
              end else if (sq_expire) begin
                ce_q  <= reload_i;
                out_q <= ~out_q;
              end else begin
                ce_q <= ce_q - step;
              end
            end
          endcase
        end
      end
      if (first_stb_i && mode_i == MODE_TC) begin
        run_q <= 1'b0;
        out_q <= 1'b0;
      end
      if (load_stb_i) pend_q <= 1'b1;
    end
  end

  assign count_o = ce_q;
  assign out_o   = out_q;
endmodule

// File: rtl/pic_timer.sv
`timescale 1ns/1ps
module pic_timer
  import pic_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              gate_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              sel_ctrl_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              out_o
);
  mode_e             mode_w, cfg_mode_w;
  logic              cfg_stb_w, first_stb_w, load_stb_w, latched_w;
  logic [CNT_W-1:0]  reload_w, count_w;

  pic_host_if #(.DW(DATA_W)) u_host (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_i),
    .rd_i        (rd_i),
    .sel_ctrl_i  (sel_ctrl_i),
    .wdata_i     (wdata_i),
    .count_i     (count_w),
    .rdata_o     (rdata_o),
    .mode_o      (mode_w),
    .cfg_mode_o  (cfg_mode_w),
    .cfg_stb_o   (cfg_stb_w),
    .first_stb_o (first_stb_w),
    .load_stb_o  (load_stb_w),
    .reload_o    (reload_w),
    .latched_o   (latched_w)
  );

  pic_count_core #(.CW(CNT_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .gate_i      (gate_i),
    .mode_i      (mode_w),
    .cfg_stb_i   (cfg_stb_w),
    .cfg_mode_i  (cfg_mode_w),
    .first_stb_i (first_stb_w),
    .load_stb_i  (load_stb_w),
    .reload_i    (reload_w),
    .count_o     (count_w),
    .out_o       (out_o)
  );
endmodule

// File: rtl/pic_timer_chk.sv
`timescale 1ns/1ps
module pic_timer_chk
  import pic_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          gate_i,
  input logic          wr_i,
  input logic          rd_i,
  input logic          sel_ctrl_i,
  input logic [3:0]    ctrl_i,
  input logic [DW-1:0] rdata_o,
  input logic          out_o,
  input mode_e         mode_i,
  input logic          latched_i
);
  logic cfg_wr;
  assign cfg_wr = wr_i & sel_ctrl_i & (ctrl_i[3:2] != 2'b00);

  assert_cfg_tc_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr && ctrl_i[1:0] == 2'b00 |=> !out_o);

  assert_cfg_other_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr && ctrl_i[1:0] != 2'b00 |=> out_o);

  assert_out_needs_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !wr_i |=> $stable(out_o));

  assert_tc_stays_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_TC && out_o && !wr_i |=> out_o);

  assert_rate_low_one_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_RATE && !out_o && tick_i && !wr_i |=> out_o);

  assert_gate_forces_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !gate_i && !wr_i && mode_i != MODE_TC |=> out_o);

  assert_latch_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched_i && !rd_i && !wr_i |=> $stable(rdata_o));
endmodule

bind pic_timer pic_timer_chk #(.DW(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .gate_i     (gate_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .sel_ctrl_i (sel_ctrl_i),
  .ctrl_i     (wdata_i[3:0]),
  .rdata_o    (rdata_o),
  .out_o      (out_o),
  .mode_i     (mode_w),
  .latched_i  (latched_w)
);

// File: tb/tb_pic_timer.sv
`timescale 1ns/1ps
module tb_pic_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       gate_i = 1'b1;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic       sel_ctrl_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       out_o;

  always #2.5 clk_i = ~clk_i;

  pic_timer dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .gate_i     (gate_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .sel_ctrl_i (sel_ctrl_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .out_o      (out_o)
  );

  typedef struct {
    string      req;
    bit         is_rd;
    logic [7:0] exp;
  } item_t;

  item_t sb_q[$];
  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 1'b0;

  // monitor: pops one expected item per falling edge and compares
  always @(negedge clk_i) begin
    if (sb_q.size() != 0) begin
      item_t      it;
      logic [7:0] act;
      it  = sb_q.pop_front();
      act = it.is_rd ? rdata_o : {7'b0, out_o};
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s: %s got %h expected %h", it.req,
                 it.is_rd ? "rdata_o" : "out_o", act, it.exp);
      end
    end
  end

  task automatic cyc();
    @(posedge clk_i);
    #1;
  endtask

  task automatic put(input string req, input bit is_rd, input logic [7:0] exp);
    item_t it;
    it.req   = req;
    it.is_rd = is_rd;
    it.exp   = exp;
    sb_q.push_back(it);
    @(negedge clk_i);
    #0.5;
  endtask

  task automatic exp_out(input string req, input bit v);
    put(req, 1'b0, {7'b0, v});
  endtask

  task automatic exp_rd(input string req, input logic [7:0] v);
    put(req, 1'b1, v);
    sel_ctrl_i = 1'b0;
    rd_i = 1'b1;
    cyc();
    rd_i = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    sel_ctrl_i = 1'b1;
    wr_i = 1'b1;
    wdata_i = d;
    cyc();
    wr_i = 1'b0;
    sel_ctrl_i = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] d);
    sel_ctrl_i = 1'b0;
    wr_i = 1'b1;
    wdata_i = d;
    cyc();
    wr_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      cyc();
    end
    tick_i = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    cyc();
    // R1 reset state
    exp_out("R1", 1'b1);
    exp_rd("R1", 8'h00);

    // R2 setup byte drives out without pulses
    wr_ctl(8'h04); exp_out("R2", 1'b0);
    wr_ctl(8'h05); exp_out("R2", 1'b1);
    wr_ctl(8'h04); exp_out("R2", 1'b0);

    // R3 load on first pulse, R4 terminal count
    wr_dat(8'h05);
    cyc(); cyc(); cyc();
    exp_out("R3", 1'b0);
    ticks(1); cyc();
    exp_rd("R3", 8'h05);
    ticks(4); exp_out("R4", 1'b0);
    ticks(1); exp_out("R4", 1'b1);
    ticks(2); exp_out("R4", 1'b1);

    // R10 freeze keeps mode and output, holds snapshot
    wr_ctl(8'h00); exp_out("R10", 1'b1);
    ticks(3); cyc();
    exp_rd("R10", 8'hFE);
    cyc();
    exp_rd("R10", 8'hFB);

    // R5 split write in terminal-count mode
    wr_ctl(8'h0C); exp_out("R2", 1'b0);
    wr_dat(8'h03); wr_dat(8'h00);
    ticks(1); ticks(3); exp_out("R4", 1'b1);
    wr_dat(8'h02); exp_out("R5", 1'b0);
    ticks(2); cyc();
    exp_rd("R5", 8'h00);
    exp_rd("R5", 8'h00);
    wr_dat(8'h00);
    ticks(1); ticks(1); exp_out("R5", 1'b0);
    ticks(1); exp_out("R5", 1'b1);

    // R12 zero count
    wr_ctl(8'h0C);
    wr_dat(8'h00); wr_dat(8'h00);
    ticks(1); ticks(1);
    exp_out("R12", 1'b0);
    cyc();
    exp_rd("R12", 8'hFF);
    exp_rd("R12", 8'hFF);

    // R6 rate strobe, N=3
    wr_ctl(8'h05); wr_dat(8'h03);
    ticks(1);
    ticks(2); exp_out("R6", 1'b0);
    ticks(1); exp_out("R6", 1'b1);
    ticks(1); exp_out("R6", 1'b1);
    ticks(1); exp_out("R6", 1'b0);

    // R8 gate low in rate mode, R9 retrigger
    wr_ctl(8'h05); wr_dat(8'h05);
    ticks(1); ticks(4); exp_out("R6", 1'b0);
    gate_i = 1'b0;
    ticks(1); exp_out("R8", 1'b1);
    ticks(2); cyc();
    exp_rd("R8", 8'h01);
    gate_i = 1'b1;
    ticks(1); cyc();
    exp_rd("R9", 8'h05);
    ticks(4); exp_out("R9", 1'b0);

    // R8 gate low holds terminal-count mode
    wr_ctl(8'h04); wr_dat(8'h04);
    ticks(1);
    gate_i = 1'b0;
    ticks(3); cyc();
    exp_rd("R8", 8'h04);
    gate_i = 1'b1;

    // R7 square wave, odd then even
    wr_ctl(8'h06); wr_dat(8'h05);
    ticks(1);
    ticks(2); exp_out("R7", 1'b1);
    ticks(1); exp_out("R7", 1'b0);
    ticks(1); exp_out("R7", 1'b0);
    ticks(1); exp_out("R7", 1'b1);
    wr_ctl(8'h06); wr_dat(8'h04);
    ticks(1);
    ticks(1); exp_out("R7", 1'b1);
    ticks(1); exp_out("R7", 1'b0);
    ticks(1); exp_out("R7", 1'b0);
    ticks(1); exp_out("R7", 1'b1);

    // R11 byte formats
    wr_ctl(8'h09); wr_dat(8'h02);
    ticks(1); cyc();
    exp_rd("R11", 8'h02);
    wr_ctl(8'h0D); wr_dat(8'h34); wr_dat(8'h12);
    ticks(1); cyc();
    exp_rd("R11", 8'h34);
    exp_rd("R11", 8'h12);

    // R10 snapshot held across both byte reads
    wr_ctl(8'h00);
    ticks(3); cyc();
    exp_rd("R10", 8'h34);
    ticks(2); cyc();
    exp_rd("R10", 8'h12);
    cyc();
    exp_rd("R10", 8'h2F);
    exp_rd("R10", 8'h12);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule